// File: doc/BRIEF.md
# Vector length configuration unit

This block carries out the configuration-setting step of a vector unit. A decoded operation arrives on a valid strobe together with its already-extracted operands. The block then settles the new element width, register grouping and policy bits, checks that the combination is legal, and works out the largest vector length that the grouping allows. From that it picks the new active length. The block owns the vector-type, vector-length and vector-start state. When an operation yields a value for the scalar register file, it returns a destination write.

Three operation kinds are accepted. The immediate-type kind takes its type fields from the instruction. The register-type kind takes them from the low byte of a source register value. The immediate-length kind takes its type from the instruction and uses the 5-bit source index field as the requested length. For the two register-source kinds, the source and destination indices select between three length modes: request a length, take the maximum, or keep the current length.

Top module: `vcfg_unit`

## Requirements
- R1: During and after reset, before any operation, the type register holds only its most significant (illegal) bit set. The length and vector-start are 0, and `done` and `rd_we` are low.
- R2: Type fields: element width 000/001/010/011 means 8/16/32/64 bits; grouping 101/110/111/000/001/010/011 means 1/8, 1/4, 1/2, 1, 2, 4, 8. A legal type is stored with mask-agnostic at bit 7, tail-agnostic at bit 6, element width at bits 5:3, grouping at bits 2:0, and all other bits zero.
- R3: A type is illegal when element width bit 2 is set, or grouping is 100, or log2(width) > log2(grouping) + log2(ELEN). Such an operation leaves the type register as only the illegal bit, sets the length to 0, writes no destination and leaves vector-start unchanged.
- R4: The maximum length is 2^(log2 VLEN + log2 grouping − log2 width).
- R5: For a requested length A and maximum M, the new length is A if A ≤ M, (A+1)/2 if M < A < 2M, and M if A ≥ 2M.
- R6: The register-type kind (`op_kind`=01) takes the type from bits 7:0 of `type_val` in the layout of R2; all higher bits of `type_val` have no effect.
- R7: For kinds 00 and 01: a nonzero `src_idx` requests `src_val` as the length; zero `src_idx` with nonzero `dst_idx` sets the maximum; both zero keeps the length. Request and maximum modes write the new length to `dst_idx`.
- R8: In keep mode, a legal new type whose width-to-grouping log ratio differs from that of the stored type fields sets the illegal-only type and length 0. A matching ratio keeps the length. Neither case writes a destination. The illegal-only type counts as the fields of 8-bit width and grouping 1.
- R9: The immediate-length kind (`op_kind`=10) uses `src_idx`, zero-extended, as the requested length. `src_val` has no effect, and the destination is always written when the type is legal.
- R10: One clock edge after a strobe of kind 00, 01 or 10, `done` pulses for one cycle. `rd_we`, `rd_idx` and `rd_data` (equal to the new length) appear in the same cycle, and vector-start reads 0.
- R11: `op_kind`=11 is ignored: no `done`, no write, and type and length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_kind | input | 2 | 00 immediate type, 01 register type, 10 immediate length, 11 ignored |
| imm_ma | input | 1 | Mask-agnostic bit from the instruction |
| imm_ta | input | 1 | Tail-agnostic bit from the instruction |
| imm_ew | input | 3 | Element width field from the instruction |
| imm_grp | input | 3 | Grouping field from the instruction |
| src_idx | input | 5 | Source register index, or immediate length |
| dst_idx | input | 5 | Destination register index |
| src_val | input | XLEN | Value of the source register |
| type_val | input | XLEN | Value of the type source register |
| vtype_q | output | XLEN | Vector-type state |
| vl_q | output | XLEN | Vector-length state |
| vstart_q | output | XLEN | Vector-start state |
| done | output | 1 | Completion pulse |
| rd_we | output | 1 | Destination write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | XLEN | Destination write data |

## Verification
Every result is registered once, so all state and the write port reflect a strobe on the first rising edge after it. The bench drives each operation on a falling edge and holds it across one rising edge. It then compares outputs on the following falling edge and checks on the next falling edge that `done` has dropped again. It sweeps every width and grouping code against lengths placed just below, at and beyond M and 2M, and across the full 5-bit immediate range. Expected values come from an arithmetic model in the bench.

// File: rtl/vcfg_unit.sv
module vcfg_unit #(
  parameter int XLEN_LOG2 = 5,
  parameter int VLEN_LOG2 = 7,
  parameter int ELEN_LOG2 = 6,
  localparam int XLEN = 1 << XLEN_LOG2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      op_kind,
  input  logic            imm_ma,
  input  logic            imm_ta,
  input  logic [2:0]      imm_ew,
  input  logic [2:0]      imm_grp,
  input  logic [4:0]      src_idx,
  input  logic [4:0]      dst_idx,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] type_val,
  output logic [XLEN-1:0] vtype_q,
  output logic [XLEN-1:0] vl_q,
  output logic [XLEN-1:0] vstart_q,
  output logic            done,
  output logic            rd_we,
  output logic [4:0]      rd_idx,
  output logic [XLEN-1:0] rd_data
);
  localparam logic [XLEN-1:0] ILL_ONLY = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic signed [7:0] ELEN_S = 8'(ELEN_LOG2);
  localparam logic signed [7:0] VLEN_S = 8'(VLEN_LOG2);

  logic go, reg_form, keep_mode, max_mode, bad_type, ratio_diff;
  logic [7:0] nt;
  logic signed [7:0] sew_new, lmul_new, sew_old, lmul_old, span;
  logic [XLEN:0] vlmax, avl, pick;

  assign go        = op_valid && (op_kind != 2'b11);
  assign reg_form  = (op_kind != 2'b10);
  assign keep_mode = reg_form && (src_idx == 5'd0) && (dst_idx == 5'd0);
  assign max_mode  = reg_form && (src_idx == 5'd0) && (dst_idx != 5'd0);
  assign nt        = (op_kind == 2'b01) ? type_val[7:0] : {imm_ma, imm_ta, imm_ew, imm_grp};

  assign sew_new  = $signed({6'b0, nt[4:3]}) + 8'sd3;
  assign lmul_new = $signed({{5{nt[2]}}, nt[2:0]});
  assign sew_old  = $signed({6'b0, vtype_q[4:3]}) + 8'sd3;
  assign lmul_old = $signed({{5{vtype_q[2]}}, vtype_q[2:0]});

  assign bad_type   = nt[5] || (nt[2:0] == 3'b100) || (sew_new > lmul_new + ELEN_S);
  assign ratio_diff = (sew_new - lmul_new) != (sew_old - lmul_old);
  assign span       = VLEN_S + lmul_new - sew_new;
  assign vlmax      = bad_type ? '0 : ((XLEN+1)'(1) << span[5:0]);

  assign avl = (op_kind == 2'b10) ? (XLEN+1)'(src_idx)
             : max_mode ? vlmax
             : {1'b0, src_val};

  always_comb begin
    if (avl <= vlmax)            pick = avl;
    else if (avl < (vlmax << 1)) pick = (avl + 1'b1) >> 1;
    else                         pick = vlmax;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vtype_q  <= ILL_ONLY;
      vl_q     <= '0;
      vstart_q <= '0;
      done     <= 1'b0;
      rd_we    <= 1'b0;
      rd_idx   <= '0;
      rd_data  <= '0;
    end else if (go) begin
      done   <= 1'b1;
      rd_idx <= dst_idx;
      if (bad_type) begin
        vtype_q <= ILL_ONLY;
        vl_q    <= '0;
        rd_we   <= 1'b0;
      end else if (keep_mode) begin
        vstart_q <= '0;
        rd_we    <= 1'b0;
        if (ratio_diff) begin
          vtype_q <= ILL_ONLY;
          vl_q    <= '0;
        end else begin
          vtype_q <= XLEN'(nt);
        end
      end else begin
        vstart_q <= '0;
        vtype_q  <= XLEN'(nt);
        vl_q     <= pick[XLEN-1:0];
        rd_we    <= 1'b1;
        rd_data  <= pick[XLEN-1:0];
      end
    end else begin
      done  <= 1'b0;
      rd_we <= 1'b0;
    end
  end

  p_ill_len_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_q[XLEN-1] |-> (vl_q == '0) && (vtype_q[XLEN-2:0] == '0));
  p_type_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vtype_q[XLEN-2:8] == '0);
  p_len_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vl_q <= XLEN'(1 << VLEN_LOG2));
  p_done_after_go_r10: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> done);
  p_write_is_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> done && (rd_data == vl_q) && (vstart_q == '0));
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> !done && !rd_we && $stable(vl_q) && $stable(vtype_q));
endmodule

// File: tb/test_vcfg_unit.sv
`timescale 1ns/1ps
module test_vcfg_unit;
  localparam int XL = 32;
  localparam int VL2 = 7;
  localparam int EL2 = 6;
  localparam logic [XL-1:0] ILL = 32'h8000_0000;

  logic clk = 0, rst_n = 0, op_valid = 0, imm_ma = 0, imm_ta = 0;
  logic [1:0] op_kind = 0;
  logic [2:0] imm_ew = 0, imm_grp = 0;
  logic [4:0] src_idx = 0, dst_idx = 0;
  logic [XL-1:0] src_val = 0, type_val = 0;
  logic [XL-1:0] vtype_q, vl_q, vstart_q, rd_data;
  logic done, rd_we;
  logic [4:0] rd_idx;

  int n_chk = 0, n_err = 0;
  logic [XL-1:0] m_type = ILL, m_vl = 0;

  always #2.5 clk = ~clk;

  vcfg_unit i_vcfg_unit (.clk, .rst_n, .op_valid, .op_kind, .imm_ma, .imm_ta,
    .imm_ew, .imm_grp, .src_idx, .dst_idx, .src_val, .type_val, .vtype_q, .vl_q,
    .vstart_q, .done, .rd_we, .rd_idx, .rd_data);

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int lg(logic [2:0] g);
    return g[2] ? int'(g) - 8 : int'(g);
  endfunction

  task automatic op(string tag, logic [1:0] kind, logic [7:0] f, logic [4:0] s,
                    logic [4:0] d, logic [XL-1:0] sv, logic [XL-1:0] tv);
    logic [7:0] nt;
    int sp, lp, osp, olp;
    bit ill, keep, mx_mode, we;
    longint mx, a, nv;
    logic [XL-1:0] etype;
    nt = (kind == 2'b01) ? tv[7:0] : f;
    sp = int'(nt[4:3]) + 3;
    lp = lg(nt[2:0]);
    osp = int'(m_type[4:3]) + 3;
    olp = lg(m_type[2:0]);
    ill = nt[5] || nt[2:0] == 3'b100 || sp > lp + EL2;
    mx = ill ? 0 : (longint'(1) << (VL2 + lp - sp));
    keep = kind != 2'b10 && s == 0 && d == 0;
    mx_mode = kind != 2'b10 && s == 0 && d != 0;
    a = (kind == 2'b10) ? longint'(s) : mx_mode ? mx : longint'(sv);
    nv = (a <= mx) ? a : (a < 2 * mx) ? (a + 1) / 2 : mx;
    we = 0;
    etype = m_type;
    if (kind != 2'b11) begin
      if (ill) begin etype = ILL; m_vl = 0; end
      else if (keep) begin
        if ((sp - lp) != (osp - olp)) begin etype = ILL; m_vl = 0; end
        else etype = XL'(nt);
      end else begin
        etype = XL'(nt); m_vl = XL'(nv); we = 1;
      end
    end
    m_type = etype;
    @(negedge clk);
    op_valid = 1; op_kind = kind;
    {imm_ma, imm_ta, imm_ew, imm_grp} = f;
    src_idx = s; dst_idx = d; src_val = sv; type_val = tv;
    @(negedge clk);
    op_valid = 0;
    chk(tag, "type", vtype_q, m_type);
    chk(tag, "len", vl_q, m_vl);
    chk(tag, "done", done, kind != 2'b11);
    chk(tag, "we", rd_we, we);
    if (we) begin
      chk("R10", "data", rd_data, m_vl);
      chk("R10", "idx", rd_idx, d);
    end
    chk("R10", "vstart", vstart_q, 0);
  endtask

  initial begin
    #3_000_000;
    n_err++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "type", vtype_q, ILL);
    chk("R1", "len", vl_q, 0);
    chk("R1", "vstart", vstart_q, 0);
    chk("R1", "done", done, 0);
    chk("R1", "we", rd_we, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "len", vl_q, 0);
    chk("R1", "type", vtype_q, ILL);

    op("R8", 2'b00, 8'b00_000_000, 0, 0, 0, 0);

    for (int e = 0; e < 8; e++)
      for (int g = 0; g < 8; g++) begin
        int lp, sp;
        longint mx;
        longint avls[10];
        lp = lg(3'(g)); sp = (e & 3) + 3;
        mx = (e >= 4 || g == 4 || sp > lp + EL2) ? 1 : (longint'(1) << (VL2 + lp - sp));
        avls = '{1, 2, mx - 1, mx, mx + 1, 2 * mx - 1, 2 * mx, 2 * mx + 1, 32'hFFFF_FFFF, 7};
        foreach (avls[k])
          op((e >= 4 || g == 4 || sp > lp + EL2) ? "R3" : (avls[k] >= 2 * mx ? "R4" : "R5"),
             2'b00, {k[0], k[1], 3'(e), 3'(g)}, 5'd1, 5'd3, XL'(avls[k]), 0);
        op("R7", 2'b00, {2'b10, 3'(e), 3'(g)}, 5'd0, 5'd7, 32'd9, 0);
        op("R2", 2'b00, {2'b01, 3'(e), 3'(g)}, 5'd4, 5'd2, 32'd0, 0);
      end

    for (int t = 0; t < 256; t += 7)
      op("R6", 2'b01, 8'hFF, 5'd2, 5'd5, 32'd50, {24'hA5C3_F0, 8'(t)});
    op("R6", 2'b01, 8'h00, 5'd2, 5'd5, 32'd3, 32'hFFFF_FF11);

    for (int e = 0; e < 8; e++)
      for (int g = 0; g < 8; g++) begin
        op("R7", 2'b00, {2'b00, 3'b010, 3'b001}, 5'd6, 5'd1, 32'd5, 0);
        op("R8", 2'b00, {2'b11, 3'(e), 3'(g)}, 5'd0, 5'd0, 32'd77, 0);
      end
    op("R8", 2'b00, {2'b00, 3'b010, 3'b001}, 5'd0, 5'd0, 0, 0);

    for (int f = 0; f < 4; f++)
      for (int u = 0; u < 32; u++) begin
        logic [7:0] ty;
        case (f)
          0: ty = {2'b00, 3'b011, 3'b000};
          1: ty = {2'b00, 3'b000, 3'b000};
          2: ty = {2'b11, 3'b000, 3'b101};
          default: ty = {2'b10, 3'b001, 3'b011};
        endcase
        op("R9", 2'b10, ty, 5'(u), 5'(u ^ 5'd9), 32'hDEAD_BEEF, 0);
      end
    op("R9", 2'b10, {2'b00, 3'b011, 3'b101}, 5'd31, 5'd4, 0, 0);

    op("R7", 2'b00, {2'b00, 3'b000, 3'b000}, 5'd3, 5'd1, 32'd11, 0);
    @(negedge clk);
    chk("R10", "done pulse", done, 0);
    chk("R10", "we pulse", rd_we, 0);
    op("R11", 2'b11, {2'b00, 3'b011, 3'b011}, 5'd3, 5'd1, 32'd2, 32'hFF);
    op("R11", 2'b11, {2'b00, 3'b000, 3'b000}, 5'd0, 5'd0, 0, 0);
    chk("R11", "len kept", vl_q, 11);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule